// File: doc/BRIEF.md
# Cumulative Distribution Sweep Sequencer

This block owns a word-addressed store and walks it with an internal address counter, one word per clock. In a sweep pass it turns a histogram held in the store into its cumulative distribution in place. Each visited word is added to the running total of every word before it, the total is written back to the same word, and the total is presented on the output. In a load pass the same counter steps through the store while input words are written to consecutive addresses, and the old contents of each address are presented on the output.

An active-low run control gates the work. While run is high the counter keeps stepping and the stored words are shown unchanged, with nothing written, so a pass with run high reads the store back. Changing the pass selection restarts the counter at address zero. In a sweep pass, the first falling edge of run after that also restarts it. In a load pass every falling edge of run restarts it. Every sample, whether written or only read, leaves the block three clock edges after it was taken. A done flag marks the moment the write at the top address has retired.

Top module: `cdf_sweep_seq`

## Requirements
- R1: While reset is held and until the first sample has had time to leave the pipeline, `dout` is zero and `done` is low.
- R2: A restart happens when `load_sel` differs from its value at the previous clock edge. It also happens on a falling edge of `run_n` in a load pass (`load_sel`=1) at any time, and in a sweep pass (`load_sel`=0) only on the first falling edge after a pass change or reset. The restarting sample addresses word 0 and starts the running total from zero.
- R3: The address advances by one per clock edge and holds at the top address (all ones). Only the first sample at the top address may write. Repeated samples there write nothing.
- R4: In a sweep pass with `run_n` low, the output is the running total plus the stored word, modulo 2^DATA_W. That value is also written back to the same address and becomes the new running total.
- R5: With `run_n` high the address still advances, nothing is written, the running total is kept, and the output is the stored word. Lowering `run_n` again in a sweep pass, other than as described in R2, resumes the total without a restart.
- R6: In a load pass with `run_n` low, `din` is written to the current address and the output is the word that address held before.
- R7: The result of a sample taken at clock edge t appears on `dout` after edge t+2, the third edge counting the sampling edge.
- R8: `done` rises when the first sample at the top address leaves the pipeline. It falls when the first sample of a restarted pass leaves the pipeline.
- R9: A sample that reads an address written by either of the two preceding samples sees the newly written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_sel | input | 1 | Pass selection: 0 sweep, 1 table load |
| run_n | input | 1 | Active-low run control |
| din | input | DATA_W | Data word written during a load pass |
| dout | output | DATA_W | Registered result per sample |
| done | output | 1 | Top-address write has retired |

## Verification
The hardest case to reach is a read that lands on an address whose write is still in the pipeline. Sequential addressing never produces it in steady state, so it only appears around restarts. The stimulus writes word 0 in a one-cycle load burst and flips the pass selection on the very next cycle, so the restarted read of word 0 comes right behind the pending write. The other hard case is the held top address. Runs are kept active several cycles past the top so that the blocked repeat writes would show up in a later read-back pass.

// File: rtl/cdf_pkg.sv
package cdf_pkg;
    typedef enum logic {
        PASS_SWEEP = 1'b0,
        PASS_LOAD  = 1'b1
    } pass_e;

    localparam int PIPE_STAGES = 3;
endpackage

// File: rtl/cdf_addr_gen.sv
module cdf_addr_gen
    import cdf_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  pass_e             pass_i,
    input  logic              run_n_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              first_o,
    output logic              en_o,
    output logic              last_o
);
    localparam logic [ADDR_W-1:0] ADDR_MAX = '1;

    typedef struct packed {
        logic [ADDR_W-1:0] cnt;
        logic              top_seen;
        logic              run_prev;
        pass_e             pass_prev;
        logic              armed;
    } ag_state_t;

    ag_state_t st_q, st_d;
    logic      restart;
    logic      blocked;

    always_comb begin
        logic mode_chg;
        logic fall;
        st_d     = st_q;
        mode_chg = (pass_i != st_q.pass_prev);
        fall     = !run_n_i && st_q.run_prev;
        restart  = mode_chg || (fall && ((pass_i == PASS_LOAD) || st_q.armed));
        blocked  = !restart && st_q.top_seen;
        addr_o   = restart ? '0 : st_q.cnt;
        first_o  = restart;
        en_o     = !run_n_i && !blocked;
        last_o   = (addr_o == ADDR_MAX) && !blocked;

        if (restart) begin
            st_d.cnt = ADDR_W'(1);
        end else if (st_q.cnt != ADDR_MAX) begin
            st_d.cnt = st_q.cnt + ADDR_W'(1);
        end
        st_d.top_seen  = (addr_o == ADDR_MAX);
        st_d.run_prev  = run_n_i;
        st_d.pass_prev = pass_i;
        if (mode_chg) begin
            st_d.armed = 1'b1;
        end else if (restart) begin
            st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, top_seen: 1'b0, run_prev: 1'b1,
                      pass_prev: PASS_SWEEP, armed: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    // R3
    cnt_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |=> (st_q.cnt >= $past(st_q.cnt)));

    // R3
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == ADDR_MAX && !restart) |=> (st_q.cnt == ADDR_MAX));
endmodule

// File: rtl/cdf_store.sv
module cdf_store #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem[waddr_i] <= wdata_i;
        end
    end

    // R9: a write in flight this cycle is forwarded to the reader
    always_comb begin
        if (we_i && (waddr_i == raddr_i)) begin
            rdata_o = wdata_i;
        end else begin
            rdata_o = mem[raddr_i];
        end
    end

    // R3
    wr_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> !(we_i && (waddr_i == $past(waddr_i))));
endmodule

// File: rtl/cdf_combine.sv
module cdf_combine
    import cdf_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  pass_e             pass_i,
    input  logic              en_i,
    input  logic              first_i,
    input  logic [DATA_W-1:0] sum_i,
    input  logic [DATA_W-1:0] rdata_i,
    input  logic [DATA_W-1:0] din_i,
    output logic [DATA_W-1:0] wdata_o,
    output logic [DATA_W-1:0] out_o,
    output logic [DATA_W-1:0] sum_o
);
    logic [DATA_W-1:0] base;
    logic [DATA_W-1:0] acc;
    logic              do_acc;

    always_comb begin
        base    = first_i ? '0 : sum_i;
        acc     = base + rdata_i;
        do_acc  = en_i && (pass_i == PASS_SWEEP);
        wdata_o = (pass_i == PASS_LOAD) ? din_i : acc;
        out_o   = do_acc ? acc : rdata_i;
        sum_o   = do_acc ? acc : base;
    end
endmodule

// File: rtl/cdf_sweep_seq.sv
module cdf_sweep_seq
    import cdf_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_sel,
    input  logic              run_n,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              done
);
    localparam logic [ADDR_W-1:0] ADDR_MAX = '1;

    typedef struct packed {
        logic              valid;
        logic              first;
        logic              en;
        logic              last;
        pass_e             pass;
        logic [DATA_W-1:0] din;
        logic [ADDR_W-1:0] addr;
    } stage_t;

    typedef struct packed {
        stage_t            s1;
        stage_t            s2;
        logic [DATA_W-1:0] rdata2;
        logic [DATA_W-1:0] sum;
        logic [DATA_W-1:0] dout;
        logic              done;
    } seq_state_t;

    seq_state_t st_q, st_d;

    logic [ADDR_W-1:0] ag_addr;
    logic              ag_first;
    logic              ag_en;
    logic              ag_last;
    logic [DATA_W-1:0] rd_data;
    logic [DATA_W-1:0] cb_wdata;
    logic [DATA_W-1:0] cb_out;
    logic [DATA_W-1:0] cb_sum;
    logic              wr_en;

    cdf_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .pass_i  (pass_e'(load_sel)),
        .run_n_i (run_n),
        .addr_o  (ag_addr),
        .first_o (ag_first),
        .en_o    (ag_en),
        .last_o  (ag_last)
    );

    assign wr_en = st_q.s2.valid && st_q.s2.en;

    cdf_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (wr_en),
        .waddr_i (st_q.s2.addr),
        .wdata_i (cb_wdata),
        .raddr_i (st_q.s1.addr),
        .rdata_o (rd_data)
    );

    cdf_combine #(.DATA_W(DATA_W)) u_comb (
        .pass_i  (st_q.s2.pass),
        .en_i    (st_q.s2.en),
        .first_i (st_q.s2.first),
        .sum_i   (st_q.sum),
        .rdata_i (st_q.rdata2),
        .din_i   (st_q.s2.din),
        .wdata_o (cb_wdata),
        .out_o   (cb_out),
        .sum_o   (cb_sum)
    );

    always_comb begin
        st_d          = st_q;
        st_d.s1.valid = 1'b1;
        st_d.s1.first = ag_first;
        st_d.s1.en    = ag_en;
        st_d.s1.last  = ag_last;
        st_d.s1.pass  = pass_e'(load_sel);
        st_d.s1.din   = din;
        st_d.s1.addr  = ag_addr;
        st_d.s2       = st_q.s1;
        st_d.rdata2   = rd_data;
        if (st_q.s2.valid) begin
            st_d.dout = cb_out;
            st_d.sum  = cb_sum;
            if (st_q.s2.last) begin
                st_d.done = 1'b1;
            end else if (st_q.s2.first) begin
                st_d.done = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.dout;
    assign done = st_q.done;

    // R2
    first_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.s1.first |-> (st_q.s1.addr == '0));

    // R5
    sum_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.s2.valid && !st_q.s2.en && !st_q.s2.first) |=> $stable(st_q.sum));

    // R8
    done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.done) |-> ($past(st_q.s2.addr) == ADDR_MAX));

    // R1
    idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.s2.valid |=> $stable(st_q.dout));
endmodule

// File: tb/sim_cdf_sweep_seq.sv
module sim_cdf_sweep_seq;
    localparam int AW    = 4;
    localparam int DW    = 8;
    localparam int DEPTH = 1 << AW;
    localparam int TOP   = DEPTH - 1;
    localparam int MASK  = (1 << DW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_sel = 1'b0;
    logic          run_n = 1'b1;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          done;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    cdf_sweep_seq #(.ADDR_W(AW), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .load_sel(load_sel), .run_n(run_n),
        .din(din), .dout(dout), .done(done)
    );

    // bench model state
    int    cnt_m = 0, sum_m = 0, wa1 = -1, wa2 = -1, j = 0;
    bit    top_m = 0, runp_m = 1, selp_m = 0, armed_m = 1, done_m = 0;
    int    mem_m [DEPTH];
    bit    known_m [DEPTH];
    int    e_out [8];
    bit    e_known [8];
    bit    e_done [8];
    string e_tag [8];

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    task automatic check_now();
        int    k;
        int    eo;
        bit    ek;
        bit    ed;
        string tg;
        if (j < 3) begin
            eo = 0; ek = 1; ed = 0; tg = "R1";
        end else begin
            k = (j - 3) % 8;
            eo = e_out[k]; ek = e_known[k]; ed = e_done[k]; tg = e_tag[k];
        end
        if (ek) begin
            checks++;
            if (int'(dout) != eo) begin
                failures++;
                $display("FAIL %s/R7 sample %0d dout=%0h expected=%0h", tg, j - 3, dout, eo);
            end
        end
        checks++;
        if (done != ed) begin
            failures++;
            $display("FAIL R8 sample %0d done=%0b expected=%0b", j - 3, done, ed);
        end
    endtask

    task automatic cyc(input bit rn, input bit ld, input int d);
        bit    mchg, fall, rs, blocked, en, last, fwd, rk;
        int    addr, rdval, base, acc, ov, k;
        string tg;
        @(negedge clk);
        check_now();
        rst_n    = 1'b1;
        run_n    = rn;
        load_sel = ld;
        din      = DW'(d);
        mchg    = (ld != selp_m);
        fall    = !rn && runp_m;
        rs      = mchg || (fall && (ld || armed_m));
        addr    = rs ? 0 : cnt_m;
        blocked = !rs && top_m;
        en      = !rn && !blocked;
        last    = (addr == TOP) && !blocked;
        fwd     = (addr == wa1) || (addr == wa2);
        rdval   = mem_m[addr];
        rk      = known_m[addr];
        ov      = rdval;
        if (ld) begin
            if (en) begin
                mem_m[addr] = d & MASK;
                known_m[addr] = 1'b1;
            end
            if (rs) sum_m = 0;
        end else begin
            base = rs ? 0 : sum_m;
            acc  = (base + rdval) & MASK;
            if (en) begin
                ov = acc;
                mem_m[addr] = acc;
                known_m[addr] = rk;
                sum_m = acc;
            end else if (rs) begin
                sum_m = 0;
            end
        end
        if (last) done_m = 1'b1;
        else if (rs) done_m = 1'b0;
        if (fwd)          tg = "R9";
        else if (rs)      tg = "R2";
        else if (blocked) tg = "R3";
        else if (!en)     tg = "R5";
        else if (ld)      tg = "R6";
        else              tg = "R4";
        k = j % 8;
        e_out[k] = ov; e_known[k] = rk; e_done[k] = done_m; e_tag[k] = tg;
        wa2 = wa1;
        wa1 = en ? addr : -1;
        cnt_m = rs ? 1 : ((cnt_m == TOP) ? TOP : cnt_m + 1);
        top_m = (addr == TOP);
        armed_m = mchg ? 1'b1 : (rs ? 1'b0 : armed_m);
        runp_m = rn;
        selp_m = ld;
        j++;
    endtask

    task automatic readback();
        cyc(1, 1, 0);
        cyc(1, 0, 0);
        for (int i = 0; i < DEPTH + 3; i++) cyc(1, 0, 0);
    endtask

    task automatic load_table(input int seed);
        cyc(1, 1, 0);
        for (int i = 0; i < DEPTH + 3; i++) cyc(0, 1, (i * seed + 11) & MASK);
        for (int i = 0; i < 3; i++) cyc(1, 1, 0);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_m[i] = 0;
            known_m[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if (dout != '0) begin
            failures++;
            $display("FAIL R1 dout=%0h expected=0", dout);
        end
        checks++;
        if (done != 1'b0) begin
            failures++;
            $display("FAIL R1 done=%0b expected=0", done);
        end
        // R1 idle, then R6 load with saturation (R3)
        for (int i = 0; i < 4; i++) cyc(1, 0, 0);
        load_table(37);
        readback();
        // R4 full sweep with wrap, then read back the distribution
        cyc(1, 0, 0);
        for (int i = 0; i < DEPTH + 3; i++) cyc(0, 0, 0);
        for (int i = 0; i < 4; i++) cyc(1, 0, 0);
        readback();
        // R5 paused sweep: resume without restart
        load_table(53);
        cyc(1, 0, 0);
        for (int i = 0; i < 5; i++) cyc(0, 0, 0);
        for (int i = 0; i < 4; i++) cyc(1, 0, 0);
        for (int i = 0; i < 10; i++) cyc(0, 0, 0);
        for (int i = 0; i < 6; i++) cyc(1, 0, 0);
        readback();
        // R2 load pass restarts on every falling edge
        cyc(1, 1, 0);
        for (int i = 0; i < 3; i++) cyc(0, 1, 200 + i);
        cyc(1, 1, 0);
        for (int i = 0; i < 3; i++) cyc(0, 1, 100 + i);
        cyc(1, 1, 0);
        readback();
        // R9 restarted read right behind a pending write of word 0
        cyc(1, 1, 0);
        cyc(0, 1, 8'hA5);
        cyc(1, 0, 0);
        cyc(1, 0, 0);
        cyc(1, 1, 0);
        cyc(0, 1, 8'h3C);
        cyc(0, 1, 8'h5A);
        cyc(1, 0, 0);
        for (int i = 0; i < 6; i++) cyc(1, 0, 0);
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired checks=%0d", checks);
            summary();
            $finish;
        end
    end
endmodule